// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Core

This block is a tiny processor whose only operation is a memory-to-memory subtract followed by a conditional jump. It has no opcode field. Each instruction is three consecutive 16-bit words. The word at the program counter names the subtrahend address A. The next word names the address B, which is both the minuend and the destination. The third word is the jump target. The core replaces the word at B with mem[B] - mem[A]. When the wrapped result is negative, the core jumps to the target. Otherwise it moves on by three words. Only the low 8 bits of an address word are used, which gives a unified 256-word store. Data and code share this store, and there is no register file visible to a program.

A host fills the store through a valid/ready port while `run` is low. Back-pressure works as follows. `host_ready` is high exactly while `run` is low. A transfer happens on a rising edge where both `host_valid` and `host_ready` are high, and a valid presented while ready is low is dropped. A read transfer (`host_we` low) returns its word on `host_rdata` after that edge. Raising `run` starts execution at address 1, since address 0 is reserved as a data word. When the next program counter would be 0, the core stops, raises `halted` and makes no further memory accesses. Lowering `run` returns the core to idle at any time, aborting any instruction in flight, and hands the store back to the host.

Top module: `subneg_core`

## Requirements
- R1: After reset with `run` low, `pc_o` reads 1, `halted` is 0 and `host_ready` is 1.
- R2: `host_ready` is 0 while `run` is high, and a host write offered while not ready leaves memory unchanged.
- R3: Each instruction stores (mem[B] - mem[A]) mod 2^16 into mem[B]. A is the low 8 bits of word pc, and B is the low 8 bits of word pc+1.
- R4: If bit 15 of the difference is 1, the next pc is the low 8 bits of word pc+2. Otherwise it is (pc + 3) mod 256. A taken jump skips the words in between.
- R5: An instruction whose A and B name the same address leaves that word 0 and does not jump.
- R6: When the next pc is 0, `halted` goes to 1 and `pc_o` reads 0. Both stay that way, with no memory access, until `run` falls.
- R7: While `run` is low, `pc_o` is 1 and `halted` is 0. After `run` rises, the first instruction fetched is at address 1.
- R8: Each instruction takes exactly 7 clock cycles. For a program that halts after N instructions, `halted` is first seen high 7N+1 rising edges after `run` rises.
- R9: Negativity is judged on the wrapped 16-bit difference. For example, 0x7FFF - 0xFFFF gives 0x8000, which causes a jump.
- R10: An accepted host read returns mem[host_addr] on `host_rdata` after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High: core executes; low: core idle, host owns memory |
| host_valid | input | 1 | Host transfer request |
| host_ready | output | 1 | High while run is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid after the accepting edge |
| halted | output | 1 | Program reached address 0 |
| pc_o | output | 8 | Program counter |

## Verification
The assertions assume that `run` stays high for the whole run of a program, apart from a deliberate stop once `halted` is high. They also assume that the host only transfers while `run` is low. The stimulus keeps to this. It loads every word with `run` low, raises `run` once per program, and waits for `halted` before lowering `run`. Its only transfer attempt while `run` is high is made on purpose, to show it is refused. The programs also keep their data words away from their code words, so that no instruction overwrites its own fetch stream.

// File: rtl/subneg_pkg.sv
package subneg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FA,
    ST_FB,
    ST_FT,
    ST_RA,
    ST_RB,
    ST_WB,
    ST_PC,
    ST_HALT
  } seq_state_e;
endpackage

// File: rtl/subneg_mem.sv
module subneg_mem #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  // single port, synchronous read with one cycle of latency
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[addr] <= wdata;
      rdata <= store[addr];
    end
  end
endmodule

// File: rtl/subneg_alu.sv
module subneg_alu #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] minuend,
  input  logic [WORD_W-1:0] subtrahend,
  output logic [WORD_W-1:0] diff,
  output logic              neg
);
  always_comb begin
    diff = minuend - subtrahend;
    neg  = diff[WORD_W-1];
  end
endmodule

// File: rtl/subneg_seq.sv
module subneg_seq
  import subneg_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] START_PC = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(3);

  seq_state_e        state;
  logic [ADDR_W-1:0] a_ptr, b_ptr, tgt, pc_next;
  logic [WORD_W-1:0] a_val, diff;
  logic              neg, neg_q;

  subneg_alu #(.WORD_W(WORD_W)) alu_i (
    .minuend   (mem_rdata),
    .subtrahend(a_val),
    .diff      (diff),
    .neg       (neg)
  );

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = diff;
    case (state)
      ST_FA: begin mem_en = 1'b1; mem_addr = pc; end
      ST_FB: begin mem_en = 1'b1; mem_addr = pc + ADDR_W'(1); end
      ST_FT: begin mem_en = 1'b1; mem_addr = pc + ADDR_W'(2); end
      ST_RA: begin mem_en = 1'b1; mem_addr = a_ptr; end
      ST_RB: begin mem_en = 1'b1; mem_addr = b_ptr; end
      ST_WB: begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = b_ptr; end
      default: ;
    endcase
  end

  always_comb pc_next = neg_q ? tgt : pc + STRIDE;

  assign halted = (state == ST_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= START_PC;
      a_ptr <= '0;
      b_ptr <= '0;
      tgt   <= '0;
      a_val <= '0;
      neg_q <= 1'b0;
    end else if (!run) begin
      state <= ST_IDLE;
      pc    <= START_PC;
    end else begin
      case (state)
        ST_IDLE: state <= ST_FA;
        ST_FA:   state <= ST_FB;
        ST_FB: begin a_ptr <= mem_rdata[ADDR_W-1:0]; state <= ST_FT; end
        ST_FT: begin b_ptr <= mem_rdata[ADDR_W-1:0]; state <= ST_RA; end
        ST_RA: begin tgt   <= mem_rdata[ADDR_W-1:0]; state <= ST_RB; end
        ST_RB: begin a_val <= mem_rdata;             state <= ST_WB; end
        ST_WB: begin neg_q <= neg;                   state <= ST_PC; end
        ST_PC: begin
          pc    <= pc_next;
          state <= (pc_next == '0) ? ST_HALT : ST_FA;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  // R7: idle core always parks its counter at the start address
  a_r7_idle_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (pc == START_PC));

  // R4: a pc update picks either the fall-through or the captured target
  a_r4_next_pc: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_PC && state != ST_IDLE) |->
      (pc == ADDR_W'($past(pc) + STRIDE) || pc == $past(tgt)));

  // R6: halt persists while run holds
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && run) |=> (state == ST_HALT));

  // R8: operand read is followed by write-back unless aborted
  a_r8_rb_to_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RB && run) |=> (state == ST_WB));
endmodule

// File: rtl/subneg_core.sv
module subneg_core #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_o
);
  logic              core_en, core_we;
  logic [ADDR_W-1:0] core_addr;
  logic [WORD_W-1:0] core_wdata;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;

  assign host_ready = !run;

  // memory owner: host while idle, sequencer while running
  always_comb begin
    if (run) begin
      mem_en    = core_en;
      mem_we    = core_we;
      mem_addr  = core_addr;
      mem_wdata = core_wdata;
    end else begin
      mem_en    = host_valid;
      mem_we    = host_valid && host_we;
      mem_addr  = host_addr;
      mem_wdata = host_wdata;
    end
  end

  subneg_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) mem_i (
    .clk  (clk),
    .en   (mem_en),
    .we   (mem_we),
    .addr (mem_addr),
    .wdata(mem_wdata),
    .rdata(mem_rdata)
  );

  subneg_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .mem_en   (core_en),
    .mem_we   (core_we),
    .mem_addr (core_addr),
    .mem_wdata(core_wdata),
    .mem_rdata(mem_rdata),
    .halted   (halted),
    .pc       (pc_o)
  );

  assign host_rdata = mem_rdata;

  // R6: a halted core leaves memory untouched
  a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && run) |-> !mem_en);

  // R2: while running, only the sequencer can write
  a_r2_host_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !core_we) |-> !mem_we);
endmodule

// File: tb/subneg_core_tb_top.sv
module subneg_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_ready, halted;
  logic [15:0] host_rdata;
  logic [7:0]  pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0]  addr;
    logic [15:0] value;
    string       tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  event      mon_ev;

  always #10 clk = ~clk;

  subneg_core dut_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .halted(halted), .pc_o(pc_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  task automatic put_instr(input logic [7:0] at, input logic [7:0] a,
                           input logic [7:0] b, input logic [7:0] t);
    host_write(at, {8'h00, a});
    host_write(at + 8'd1, {8'h00, b});
    host_write(at + 8'd2, {8'h00, t});
  endtask

  // driver: issue a read and push the expected word for the monitor
  task automatic expect_word(input logic [7:0] a, input logic [15:0] d, input string tag);
    exp_item_t it;
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b0; host_addr = a;
    it.addr = a; it.value = d; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    host_valid = 1'b0;
    -> mon_ev;
    #1;
  endtask

  // monitor: compare the returned word against the queue head
  initial begin
    forever begin
      @(mon_ev);
      if (exp_q.size() > 0) begin
        exp_item_t it;
        it = exp_q.pop_front();
        check(host_rdata === it.value, it.tag, int'(host_rdata), int'(it.value));
      end
    end
  end

  task automatic run_prog(input int exp_cycles, input string tag);
    int n = 0;
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (halted) break;
    end
    check(halted === 1'b1, "R6", int'(halted), 1);
    check(n == exp_cycles, tag, n, exp_cycles);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc_o == 8'd1, "R1", int'(pc_o), 1);
    check(halted === 1'b0, "R1", int'(halted), 0);
    check(host_ready === 1'b1, "R1", int'(host_ready), 1);

    // program A: S = X + Y through temporary T, then halt
    host_write(8'h40, 16'd1234);
    host_write(8'h41, 16'd567);
    host_write(8'h42, 16'h5555);
    host_write(8'h43, 16'h7777);
    host_write(8'h45, 16'd1);
    host_write(8'h46, 16'd0);
    put_instr(8'd1,  8'h42, 8'h42, 8'd4);
    put_instr(8'd4,  8'h43, 8'h43, 8'd7);
    put_instr(8'd7,  8'h40, 8'h43, 8'd10);
    put_instr(8'd10, 8'h41, 8'h43, 8'd13);
    put_instr(8'd13, 8'h43, 8'h42, 8'd16);
    put_instr(8'd16, 8'h45, 8'h46, 8'd0);
    expect_word(8'h40, 16'd1234, "R10");
    run_prog(43, "R8");
    check(pc_o == 8'd0, "R6", int'(pc_o), 0);

    // R2: refused write while running, halt holds
    check(host_ready === 1'b0, "R2", int'(host_ready), 0);
    host_write(8'h40, 16'hDEAD);
    repeat (4) @(negedge clk);
    check(halted === 1'b1, "R6", int'(halted), 1);
    run = 1'b0;
    @(negedge clk);
    check(pc_o == 8'd1, "R7", int'(pc_o), 1);
    check(halted === 1'b0, "R7", int'(halted), 0);
    expect_word(8'h40, 16'd1234, "R2");
    expect_word(8'h41, 16'd567, "R3");
    expect_word(8'h42, 16'd1801, "R3");
    expect_word(8'h43, 16'hF8F7, "R3");
    expect_word(8'h46, 16'hFFFF, "R3");

    // program B: wrapped sign, skip, clear, halt
    host_write(8'h50, 16'hFFFF);
    host_write(8'h51, 16'h7FFF);
    host_write(8'h52, 16'd5);
    host_write(8'h53, 16'd5);
    host_write(8'h54, 16'd3);
    host_write(8'h55, 16'd2);
    host_write(8'h56, 16'd10);
    host_write(8'h57, 16'd1);
    put_instr(8'd1,  8'h50, 8'h51, 8'd20);
    put_instr(8'd4,  8'h57, 8'h56, 8'd0);
    put_instr(8'd20, 8'h52, 8'h53, 8'd0);
    put_instr(8'd23, 8'h54, 8'h55, 8'd0);
    run_prog(22, "R8");
    run = 1'b0;
    @(negedge clk);
    expect_word(8'h51, 16'h8000, "R9");
    expect_word(8'h56, 16'd10, "R4");
    expect_word(8'h53, 16'd0, "R5");
    expect_word(8'h55, 16'hFFFF, "R4");

    // program C: one halting instruction at the start address
    host_write(8'h60, 16'd9);
    host_write(8'h61, 16'd4);
    put_instr(8'd1, 8'h60, 8'h61, 8'd0);
    run_prog(8, "R7");
    run = 1'b0;
    @(negedge clk);
    expect_word(8'h61, 16'hFFFB, "R3");

    finish_run();
  end
endmodule